// File: doc/BRIEF.md
# Segment/Page Table Address Translator

This block walks two levels of translation tables held in memory and turns a virtual address into a real address. A requester presents a virtual address while the block is idle. At that moment the block samples its controls: a translation-enable bit, an addressing-width select, the origin of the segment table and the highest legal segment index. The walker then reads the segment entry and the page entry through a single memory read port. It returns either a real address or an exception code.

Pages are 4 KB and segments are 1 MB. A 31-bit virtual address therefore splits into an 11-bit segment index (bits 30:20), an 8-bit page index (bits 19:12) and a 12-bit byte offset (bits 11:0). In 24-bit mode the upper seven bits are forced to zero before the split. Faults are detected in a fixed order, and the walk stops at the first one. The result stays on the response port until the requester acknowledges it.

Top module: `dat_walker`

## Requirements
- R1: With `xlate_en` low at acceptance, the response carries code 0 and a real address equal to the zero-extended virtual address. No memory read is made, and `rsp_valid` is visible one clock edge after acceptance.
- R2: With `wide_mode` low, bits 30:24 of `req_vaddr` are treated as zero. With `wide_mode` high, all 31 bits are used. The segment index is bits 30:20, the page index is bits 19:12 and the offset is bits 11:0 of the extended address.
- R3: A segment index greater than `seg_limit` returns code 1 (segment length) without any memory read, one edge after acceptance. An index equal to the limit is legal.
- R4: The segment entry is read from `sto_base + 4*segment index`. If bit 31 of that entry is set, the walk returns code 2 (segment invalid) and makes no page read.
- R5: The page entry is read from (segment entry bits 30:0) + 4*page index. If bit 30 (allocated) of the page entry is clear, the walk returns code 3, whatever bit 31 holds.
- R6: A page entry with bit 30 set and bit 31 (invalid) set returns code 4 (page fault).
- R7: A page entry with bit 30 set and bit 31 clear returns code 0 and a real address of {page entry bits 18:0, offset}.
- R8: The response stays valid and unchanged until `rsp_ack`, and clears on the edge where the acknowledge is sampled. `rsp_fault_va` holds the extended virtual address when the code is nonzero and holds 0 otherwise. `rsp_raddr` is 0 when the code is nonzero.
- R9: The enable, width, origin and limit inputs are sampled only at acceptance. Changing them during a walk has no effect on that walk's reads or its result.
- R10: `mem_rd_en` is a single-cycle pulse for each table read. The walker waits any number of cycles for `mem_rd_valid`. A walk that makes one read responds 3 + L edges after acceptance, and one that makes two reads responds 5 + 2L edges after acceptance, where L is the number of extra cycles of memory latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xlate_en | input | 1 | Translation enable |
| wide_mode | input | 1 | 1 = 31-bit addresses, 0 = 24-bit addresses |
| sto_base | input | 31 | Segment table origin, byte address |
| seg_limit | input | 11 | Highest legal segment index |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 31 | Virtual address to translate |
| req_ready | output | 1 | Walker idle, request accepted this cycle |
| mem_rd_en | output | 1 | Table read request pulse |
| mem_rd_addr | output | 31 | Table entry byte address |
| mem_rd_data | input | 32 | Table entry read data |
| mem_rd_valid | input | 1 | Read data valid |
| rsp_valid | output | 1 | Result held |
| rsp_exc | output | 3 | 0 ok, 1 length, 2 segment invalid, 3 not allocated, 4 page fault |
| rsp_raddr | output | 31 | Real address |
| rsp_fault_va | output | 31 | Faulting extended virtual address |
| rsp_ack | input | 1 | Result acknowledge |

## Verification
A wrong walk state shows first at the read port. A misformed index or stale origin produces a wrong `mem_rd_addr` in the very cycle of the read, so the bench compares every read address against its model as it happens. A wrong decode or a lost captured field shows as a wrong code, address or latency on the edge the response rises. A broken hold register shows within the cycles the bench holds off its acknowledge.

// File: rtl/dat_pkg.sv
package dat_pkg;
    localparam int VA_W        = 31;
    localparam int NARROW_W    = 24;
    localparam int OFF_W       = 12;
    localparam int PIDX_W      = 8;
    localparam int SIDX_W      = VA_W - PIDX_W - OFF_W;
    localparam int RA_W        = 31;
    localparam int FRAME_W     = RA_W - OFF_W;
    localparam int WORD_W      = 32;
    localparam int INV_BIT     = 31;
    localparam int ALLOC_BIT   = 30;
    localparam int ENTRY_SHIFT = 2;
    localparam int EXC_W       = 3;

    typedef enum logic [EXC_W-1:0] {
        EXC_NONE      = 3'd0,
        EXC_SEG_LEN   = 3'd1,
        EXC_SEG_INV   = 3'd2,
        EXC_NOT_ALLOC = 3'd3,
        EXC_PAGE      = 3'd4
    } exc_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SEG_RQ,
        S_SEG_WT,
        S_PG_RQ,
        S_PG_WT,
        S_HOLD
    } walk_e;

    typedef struct packed {
        logic [SIDX_W-1:0] sidx;
        logic [PIDX_W-1:0] pidx;
        logic [OFF_W-1:0]  off;
    } va_t;

    typedef struct packed {
        exc_e             exc;
        logic [RA_W-1:0]  raddr;
        logic [VA_W-1:0]  fault_va;
    } result_t;

    // byte address of entry number idx in a table of 4-byte entries
    function automatic logic [RA_W-1:0] entry_addr(input logic [RA_W-1:0] base,
                                                   input logic [RA_W-1:0] idx);
        return base + (idx << ENTRY_SHIFT);
    endfunction
endpackage

// File: rtl/dat_va_split.sv
module dat_va_split import dat_pkg::*; (
    input  logic            wide_mode,
    input  logic [VA_W-1:0] raw_va,
    output va_t             va
);
    logic [VA_W-1:0] ext;

    generate
        if (NARROW_W < VA_W) begin : g_narrow
            always_comb begin
                ext = raw_va;
                if (!wide_mode) ext[VA_W-1:NARROW_W] = '0;
            end
        end else begin : g_full
            logic unused_mode;
            assign unused_mode = wide_mode;
            assign ext = raw_va;
        end
    endgenerate

    assign va = va_t'(ext);
endmodule

// File: rtl/dat_entry_decode.sv
module dat_entry_decode import dat_pkg::*; #(
    parameter bit IS_PAGE = 1'b0
) (
    input  logic [WORD_W-1:0]  word,
    output exc_e               exc,
    output logic [RA_W-1:0]    origin,
    output logic [FRAME_W-1:0] frame
);
    generate
        if (IS_PAGE) begin : g_page
            logic unused_rsvd;
            assign unused_rsvd = ^word[ALLOC_BIT-1:FRAME_W];
            assign origin = '0;
            assign frame  = word[FRAME_W-1:0];
            // allocation is judged before residency
            always_comb begin
                if (!word[ALLOC_BIT])    exc = EXC_NOT_ALLOC;
                else if (word[INV_BIT])  exc = EXC_PAGE;
                else                     exc = EXC_NONE;
            end
        end else begin : g_seg
            assign origin = word[RA_W-1:0];
            assign frame  = '0;
            assign exc    = word[INV_BIT] ? EXC_SEG_INV : EXC_NONE;
        end
    endgenerate
endmodule

// File: rtl/dat_result_hold.sv
module dat_result_hold import dat_pkg::*; (
    input  logic    clk,
    input  logic    rst,
    input  logic    load,
    input  result_t load_res,
    input  logic    ack,
    output logic    valid,
    output result_t res
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            res   <= '0;
        end else if (load) begin
            valid <= 1'b1;
            res   <= load_res;
        end else if (ack && valid) begin
            valid <= 1'b0;
        end
    end

    // R8: result stays put until acknowledged
    a_r8_held_until_ack: assert property (@(posedge clk) disable iff (rst)
        (valid && !ack) |=> (valid && $stable(res)));

    // R8: acknowledge retires the result
    a_r8_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (valid && ack && !load) |=> !valid);
endmodule

// File: rtl/dat_walker.sv
module dat_walker import dat_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              xlate_en,
    input  logic              wide_mode,
    input  logic [RA_W-1:0]   sto_base,
    input  logic [SIDX_W-1:0] seg_limit,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_vaddr,
    output logic              req_ready,
    output logic              mem_rd_en,
    output logic [RA_W-1:0]   mem_rd_addr,
    input  logic [WORD_W-1:0] mem_rd_data,
    input  logic              mem_rd_valid,
    output logic              rsp_valid,
    output logic [EXC_W-1:0]  rsp_exc,
    output logic [RA_W-1:0]   rsp_raddr,
    output logic [VA_W-1:0]   rsp_fault_va,
    input  logic              rsp_ack
);
    walk_e              state, state_n;
    va_t                va_in, va_q;
    logic [VA_W-1:0]    va_in_vec, va_q_vec;
    logic [RA_W-1:0]    sto_q, pto_q;
    logic               walk_ld, pto_ld, res_ld;
    result_t            res_in, res_q;
    exc_e               seg_exc, pg_exc;
    logic [RA_W-1:0]    seg_origin, unused_pg_origin;
    logic [FRAME_W-1:0] pg_frame, unused_seg_frame;

    dat_va_split u_split (
        .wide_mode (wide_mode),
        .raw_va    (req_vaddr),
        .va        (va_in)
    );

    dat_entry_decode #(.IS_PAGE(1'b0)) u_seg_dec (
        .word   (mem_rd_data),
        .exc    (seg_exc),
        .origin (seg_origin),
        .frame  (unused_seg_frame)
    );

    dat_entry_decode #(.IS_PAGE(1'b1)) u_pg_dec (
        .word   (mem_rd_data),
        .exc    (pg_exc),
        .origin (unused_pg_origin),
        .frame  (pg_frame)
    );

    assign va_in_vec = va_in;
    assign va_q_vec  = va_q;

    always_comb begin
        state_n          = state;
        walk_ld          = 1'b0;
        pto_ld           = 1'b0;
        res_ld           = 1'b0;
        res_in.exc       = EXC_NONE;
        res_in.raddr     = '0;
        res_in.fault_va  = '0;
        mem_rd_en        = 1'b0;
        mem_rd_addr      = '0;
        case (state)
            S_IDLE: begin
                if (req_valid) begin
                    if (!xlate_en) begin
                        res_ld       = 1'b1;
                        res_in.raddr = RA_W'(va_in_vec);
                        state_n      = S_HOLD;
                    end else if (va_in.sidx > seg_limit) begin
                        res_ld          = 1'b1;
                        res_in.exc      = EXC_SEG_LEN;
                        res_in.fault_va = va_in_vec;
                        state_n         = S_HOLD;
                    end else begin
                        walk_ld = 1'b1;
                        state_n = S_SEG_RQ;
                    end
                end
            end
            S_SEG_RQ: begin
                mem_rd_en   = 1'b1;
                mem_rd_addr = entry_addr(sto_q, RA_W'(va_q.sidx));
                state_n     = S_SEG_WT;
            end
            S_SEG_WT: begin
                if (mem_rd_valid) begin
                    if (seg_exc != EXC_NONE) begin
                        res_ld          = 1'b1;
                        res_in.exc      = seg_exc;
                        res_in.fault_va = va_q_vec;
                        state_n         = S_HOLD;
                    end else begin
                        pto_ld  = 1'b1;
                        state_n = S_PG_RQ;
                    end
                end
            end
            S_PG_RQ: begin
                mem_rd_en   = 1'b1;
                mem_rd_addr = entry_addr(pto_q, RA_W'(va_q.pidx));
                state_n     = S_PG_WT;
            end
            S_PG_WT: begin
                if (mem_rd_valid) begin
                    res_ld  = 1'b1;
                    state_n = S_HOLD;
                    if (pg_exc == EXC_NONE) begin
                        res_in.raddr = {pg_frame, va_q.off};
                    end else begin
                        res_in.exc      = pg_exc;
                        res_in.fault_va = va_q_vec;
                    end
                end
            end
            S_HOLD: begin
                if (rsp_ack) state_n = S_IDLE;
            end
            default: state_n = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            va_q  <= '0;
            sto_q <= '0;
            pto_q <= '0;
        end else begin
            state <= state_n;
            if (walk_ld) begin
                va_q  <= va_in;
                sto_q <= sto_base;
            end
            if (pto_ld) pto_q <= seg_origin;
        end
    end

    dat_result_hold u_hold (
        .clk      (clk),
        .rst      (rst),
        .load     (res_ld),
        .load_res (res_in),
        .ack      (rsp_ack),
        .valid    (rsp_valid),
        .res      (res_q)
    );

    assign req_ready    = (state == S_IDLE);
    assign rsp_exc      = res_q.exc;
    assign rsp_raddr    = res_q.raddr;
    assign rsp_fault_va = res_q.fault_va;

    // R10: each table read is a one-cycle pulse
    a_r10_read_pulse: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |=> !mem_rd_en);

    // R8: response valid exactly while the walker holds a result
    a_r8_valid_in_hold: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (state == S_HOLD));
    a_r8_hold_has_valid: assert property (@(posedge clk) disable iff (rst)
        (state == S_HOLD) |-> rsp_valid);

    // R3: a length fault comes straight from idle, with no table read
    a_r3_len_no_fetch: assert property (@(posedge clk) disable iff (rst)
        ($rose(rsp_valid) && rsp_exc == EXC_SEG_LEN) |-> ($past(state) == S_IDLE));

    // R4: segment invalid only after the segment entry returns
    a_r4_seg_inv_source: assert property (@(posedge clk) disable iff (rst)
        ($rose(rsp_valid) && rsp_exc == EXC_SEG_INV) |-> ($past(state) == S_SEG_WT));

    // R5/R6: page-level codes only after the page entry returns
    a_r5_page_codes_source: assert property (@(posedge clk) disable iff (rst)
        ($rose(rsp_valid) && (rsp_exc == EXC_NOT_ALLOC || rsp_exc == EXC_PAGE))
        |-> ($past(state) == S_PG_WT));

    // R1: requests are only taken when idle and no result is pending
    a_r1_ready_excl: assert property (@(posedge clk) disable iff (rst)
        !(req_ready && rsp_valid));
endmodule

// File: tb/tb_dat_walker.sv
`timescale 1ns/1ps
module tb_dat_walker;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        xlate_en = 1'b0;
    logic        wide_mode = 1'b0;
    logic [30:0] sto_base = '0;
    logic [10:0] seg_limit = '0;
    logic        req_valid = 1'b0;
    logic [30:0] req_vaddr = '0;
    logic        req_ready;
    logic        mem_rd_en;
    logic [30:0] mem_rd_addr;
    logic [31:0] mem_rd_data = '0;
    logic        mem_rd_valid = 1'b0;
    logic        rsp_valid;
    logic [2:0]  rsp_exc;
    logic [30:0] rsp_raddr;
    logic [30:0] rsp_fault_va;
    logic        rsp_ack = 1'b0;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    dat_walker dut (
        .clk(clk), .rst(rst), .xlate_en(xlate_en), .wide_mode(wide_mode),
        .sto_base(sto_base), .seg_limit(seg_limit), .req_valid(req_valid),
        .req_vaddr(req_vaddr), .req_ready(req_ready), .mem_rd_en(mem_rd_en),
        .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .mem_rd_valid(mem_rd_valid), .rsp_valid(rsp_valid), .rsp_exc(rsp_exc),
        .rsp_raddr(rsp_raddr), .rsp_fault_va(rsp_fault_va), .rsp_ack(rsp_ack)
    );

    // behavioural table memory
    logic [31:0] mem [logic [30:0]];
    int          mem_lat = 0;
    logic        pend = 1'b0;
    int          pcnt = 0;
    logic [30:0] paddr = '0;

    function automatic logic [31:0] rd_word(input logic [30:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    always @(negedge clk) begin
        mem_rd_valid = 1'b0;
        if (pend) begin
            if (pcnt == 0) begin
                mem_rd_valid = 1'b1;
                mem_rd_data  = rd_word(paddr);
                pend = 1'b0;
            end else begin
                pcnt = pcnt - 1;
            end
        end
        if (mem_rd_en) begin
            pend  = 1'b1;
            pcnt  = mem_lat;
            paddr = mem_rd_addr;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    // reference model from the requirements
    task automatic model(input logic [30:0] va, input bit en, input bit wide,
                         input logic [30:0] sto, input logic [10:0] lim,
                         output int exc, output logic [30:0] ra, output logic [30:0] fva,
                         output int nrd, output logic [30:0] a0, output logic [30:0] a1);
        logic [30:0] ev;
        logic [31:0] se, pe;
        ev  = wide ? va : (va & 31'h00FF_FFFF);
        exc = 0; ra = '0; fva = '0; nrd = 0; a0 = '0; a1 = '0;
        if (!en) begin
            ra = ev;
            return;
        end
        if (ev[30:20] > lim) begin
            exc = 1; fva = ev;
            return;
        end
        a0 = sto + {18'b0, ev[30:20], 2'b00};
        nrd = 1;
        se = rd_word(a0);
        if (se[31]) begin
            exc = 2; fva = ev;
            return;
        end
        a1 = se[30:0] + {21'b0, ev[19:12], 2'b00};
        nrd = 2;
        pe = rd_word(a1);
        if (!pe[30])      begin exc = 3; fva = ev; end
        else if (pe[31])  begin exc = 4; fva = ev; end
        else              ra = {pe[18:0], ev[11:0]};
    endtask

    task automatic run(input logic [30:0] va, input int lat, input bit disturb,
                       input string tag);
        int exc, nrd, cnt, k, explat;
        logic [30:0] ra, fva, a0, a1;
        logic sv_en, sv_wide;
        logic [30:0] sv_sto;
        logic [10:0] sv_lim;
        logic [2:0]  h_exc;
        logic [30:0] h_ra, h_fva;
        bit stable;
        model(va, xlate_en, wide_mode, sto_base, seg_limit, exc, ra, fva, nrd, a0, a1);
        explat = (nrd == 0) ? 1 : (nrd == 1) ? 3 + lat : 5 + 2 * lat;
        mem_lat = lat;
        sv_en = xlate_en; sv_wide = wide_mode; sv_sto = sto_base; sv_lim = seg_limit;
        @(negedge clk);
        chk(req_ready == 1'b1, tag, "ready before request", req_ready, 1);
        req_valid = 1'b1;
        req_vaddr = va;
        @(negedge clk);
        req_valid = 1'b0;
        req_vaddr = 31'h7FFF_FFFF;
        if (disturb) begin
            sto_base  = 31'h7777_0000;
            seg_limit = '0;
            xlate_en  = 1'b0;
            wide_mode = ~wide_mode;
        end
        cnt = 1;
        k = 0;
        forever begin
            if (mem_rd_en) begin
                if (k == 0)      chk(mem_rd_addr == a0, tag, "segment entry address", mem_rd_addr, a0);
                else if (k == 1) chk(mem_rd_addr == a1, tag, "page entry address", mem_rd_addr, a1);
                else             chk(1'b0, tag, "extra table read", k, nrd);
                k++;
            end
            if (rsp_valid || cnt >= 200) break;
            @(negedge clk);
            cnt++;
        end
        chk(cnt == explat, tag, "response latency (R10)", cnt, explat);
        chk(k == nrd, tag, "table read count", k, nrd);
        chk(rsp_exc == 3'(exc), tag, "exception code", rsp_exc, exc);
        chk(rsp_raddr == ra, tag, "real address", rsp_raddr, ra);
        chk(rsp_fault_va == fva, tag, "fault address (R8)", rsp_fault_va, fva);
        h_exc = rsp_exc; h_ra = rsp_raddr; h_fva = rsp_fault_va;
        stable = 1'b1;
        repeat (3) begin
            @(negedge clk);
            if (!rsp_valid || rsp_exc != h_exc || rsp_raddr != h_ra ||
                rsp_fault_va != h_fva || mem_rd_en) stable = 1'b0;
        end
        chk(stable, tag, "R8 result held until ack", stable, 1);
        rsp_ack = 1'b1;
        @(negedge clk);
        rsp_ack = 1'b0;
        chk(!rsp_valid && req_ready, tag, "R8 ack retires result", rsp_valid, 0);
        if (disturb) begin
            xlate_en = sv_en; wide_mode = sv_wide; sto_base = sv_sto; seg_limit = sv_lim;
        end
    endtask

    initial begin
        #(8 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        mem[31'h1000] = 32'h0000_2000;
        mem[31'h1004] = 32'h8000_0000;
        mem[31'h1008] = 32'h0000_3000;
        mem[31'h1014] = 32'h0000_4000;
        mem[31'h2000] = 32'h4000_0ABC;
        mem[31'h2004] = 32'h0000_0123;
        mem[31'h2008] = 32'h8000_0000;
        mem[31'h200C] = 32'hC000_0ABC;
        mem[31'h43FC] = 32'h4007_FFFF;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready && !rsp_valid && !mem_rd_en, "R8", "reset state idle, no result",
            {req_ready, rsp_valid, mem_rd_en}, 3'b100);

        // translation off
        xlate_en = 1'b0; wide_mode = 1'b1;
        run(31'h7ABC_DEF1, 0, 1'b0, "R1 wide pass-through");
        wide_mode = 1'b0;
        run(31'h7F12_3456, 0, 1'b0, "R1 R2 narrow pass-through");

        // translation on
        xlate_en = 1'b1; sto_base = 31'h1000; seg_limit = 11'd5;
        run(31'h7F00_0ABC, 0, 1'b0, "R2 R7 narrow masks high bits");
        wide_mode = 1'b1;
        run(31'h7F00_0ABC, 0, 1'b0, "R2 R3 wide keeps high bits");
        wide_mode = 1'b0;
        run(31'h005F_F001, 0, 1'b0, "R3 R7 index equal to limit");
        run(31'h0060_0000, 0, 1'b0, "R3 index above limit");
        run(31'h0010_0000, 0, 1'b0, "R4 segment invalid");
        run(31'h0000_1000, 0, 1'b0, "R5 not allocated");
        run(31'h0000_2000, 0, 1'b0, "R5 not allocated beats invalid");
        run(31'h0000_3123, 0, 1'b0, "R6 page fault");
        run(31'h0021_0000, 0, 1'b0, "R5 empty page entry");
        run(31'h0000_0777, 3, 1'b0, "R10 R7 slow memory");
        run(31'h0000_3000, 2, 1'b0, "R10 R6 slow memory");
        run(31'h0010_0000, 4, 1'b0, "R10 R4 slow memory");
        run(31'h005F_F0AA, 1, 1'b1, "R9 controls changed mid-walk");
        seg_limit = 11'd0;
        run(31'h0010_0000, 0, 1'b0, "R3 zero limit rejects index 1");
        run(31'h0000_0001, 0, 1'b0, "R3 R7 zero limit accepts index 0");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule